// File: doc/BRIEF.md
# Register-Range Load/Store-Multiple Sequencer

This block turns a single load-multiple or store-multiple operation into a chain of one-word memory transfers, one for each register in a contiguous range of register numbers. A start handshake supplies the direction, the first and the last register index, and a base address. The block keeps a running register index and a running address. It issues one memory request per step and advances both after each accepted transfer. It stops on the transfer whose index equals the last index.

Stores walk upward: the index rises by one and the address rises by one word. Loads walk downward: the index falls by one and the address falls by one word. A load range therefore starts at the higher register number, so a stored block is restored in mirror order. After each transfer except the final one, the address is advanced. The final transfer leaves the address alone, and that address goes back to the address register through a one-cycle write-back pulse.

The running index and address are visible at all times. When an abort input stops a sequence, software can resume it by issuing a new start with those two values.

The start port and the memory request port are valid/ready. A start is taken only when `start_ready` is high, which is true whenever the block is idle. A memory request stays valid, with its fields unchanged, until `mem_req_ready` accepts it. For loads, the read data must be present on `mem_rdata` in the cycle of acceptance.

Top module: `regrange_xfer_seq`

## Requirements
- R1: After reset, `busy`, `mem_req_valid` and `addr_wb_valid` are 0 and `start_ready` is 1.
- R2: A start accepted at a clock edge (`start_valid` and `start_ready` high) makes `busy` 1, `cur_idx` equal to `start_first` and `cur_addr` equal to `start_base` after that edge.
- R3: Store (`start_is_load`=0): each request has `mem_req_write`=1 and address `cur_addr`. It reads register `cur_idx` through `rf_rd_idx` and sends `rf_rd_data` as `mem_req_wdata`. Each accepted non-final transfer adds 1 to the index and 8 to the address.
- R4: Load (`start_is_load`=1): each request has `mem_req_write`=0. In the accepted cycle, `rf_wr_en`=1, `rf_wr_idx`=`cur_idx` and `rf_wr_data`=`mem_rdata`. Each accepted non-final transfer subtracts 1 from the index and 8 from the address.
- R5: The sequence ends after the transfer whose index equals the last index. Indices wrap modulo 64, so a sequence makes ((last−first) mod 64)+1 transfers for stores and ((first−last) mod 64)+1 for loads. `busy` is 0 from the edge after the final acceptance.
- R6: The final transfer leaves the address unchanged. In the cycle after it, `addr_wb_valid` is 1 for exactly one cycle, with `addr_wb_value` equal to the final transfer's address.
- R7: While `busy` is 1 and `abort` is 0, `mem_req_valid` is 1. An unaccepted request keeps its address, index and write flag into the next cycle. `mem_req_valid` is never 1 while idle.
- R8: While `busy` is 1, `start_ready` is 0 and a `start_valid` pulse changes neither the running index nor the running address.
- R9: While `abort` is 1, `mem_req_valid` is 0. Abort while busy makes the block idle at the next edge, keeps `cur_idx` and `cur_addr` at the next pending transfer, and produces no write-back. A new start from those values completes the rest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_valid | input | 1 | Start request valid |
| start_ready | output | 1 | Start can be accepted (idle) |
| start_is_load | input | 1 | 1 = load-multiple, 0 = store-multiple |
| start_first | input | 6 | First register index |
| start_last | input | 6 | Terminating register index |
| start_base | input | 32 | Initial address |
| abort | input | 1 | Stop the running sequence, keep progress |
| busy | output | 1 | Sequence in progress |
| cur_idx | output | 6 | Running register index (progress) |
| cur_addr | output | 32 | Running address (progress) |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Memory byte address |
| mem_req_wdata | output | 64 | Store data |
| mem_rdata | input | 64 | Load data, valid in the accepted cycle |
| rf_rd_idx | output | 6 | Register file read index |
| rf_rd_data | input | 64 | Register file read data |
| rf_wr_en | output | 1 | Register file write enable |
| rf_wr_idx | output | 6 | Register file write index |
| rf_wr_data | output | 64 | Register file write data |
| addr_wb_valid | output | 1 | Final address write-back pulse |
| addr_wb_value | output | 32 | Address written back |

## Verification
If the running index or address is corrupted, the damage shows at the ports on the very next request. `mem_req_addr` and `rf_rd_idx`/`rf_wr_idx` expose both values in every busy cycle, so a wrong step or a missed hold under back-pressure is visible one cycle after it occurs. A broken end comparison shows up in the transfer count and in the fall of `busy`. This happens within the same sequence, either as an extra or missing transfer or as a wrap past the last index. A wrong final-step rule shows up as a write-back value one word off, in the cycle after the last acceptance.

// File: rtl/regrange_xfer_pkg.sv
package regrange_xfer_pkg;
  typedef enum logic {
    DIR_STORE_UP = 1'b0,
    DIR_LOAD_DOWN = 1'b1
  } walk_dir_e;
endpackage

// File: rtl/rr_idx_stepper.sv
module rr_idx_stepper
  import regrange_xfer_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic [IDX_W-1:0] idx_now,
  input  logic [IDX_W-1:0] idx_stop,
  input  walk_dir_e        dir,
  output logic [IDX_W-1:0] idx_next,
  output logic             at_stop
);
  localparam logic [IDX_W-1:0] ONE = IDX_W'(1);

  // register numbers wrap modulo 2**IDX_W in both directions
  always_comb begin
    idx_next = (dir == DIR_LOAD_DOWN) ? idx_now - ONE : idx_now + ONE;
    at_stop  = (idx_now == idx_stop);
  end
endmodule

// File: rtl/rr_addr_stepper.sv
module rr_addr_stepper
  import regrange_xfer_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 8
) (
  input  logic [ADDR_W-1:0] addr_now,
  input  walk_dir_e         dir,
  output logic [ADDR_W-1:0] addr_next
);
  localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(WORD_BYTES);

  always_comb begin
    addr_next = (dir == DIR_LOAD_DOWN) ? addr_now - STRIDE : addr_now + STRIDE;
  end
endmodule

// File: rtl/regrange_xfer_seq.sv
module regrange_xfer_seq
  import regrange_xfer_pkg::*;
#(
  parameter int IDX_W      = 6,
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 64,
  parameter int WORD_BYTES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  output logic              start_ready,
  input  logic              start_is_load,
  input  logic [IDX_W-1:0]  start_first,
  input  logic [IDX_W-1:0]  start_last,
  input  logic [ADDR_W-1:0] start_base,
  input  logic              abort,
  output logic              busy,
  output logic [IDX_W-1:0]  cur_idx,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [IDX_W-1:0]  rf_rd_idx,
  input  logic [DATA_W-1:0] rf_rd_data,
  output logic              rf_wr_en,
  output logic [IDX_W-1:0]  rf_wr_idx,
  output logic [DATA_W-1:0] rf_wr_data,
  output logic              addr_wb_valid,
  output logic [ADDR_W-1:0] addr_wb_value
);
  logic              busy_q;
  walk_dir_e         dir_q;
  logic [IDX_W-1:0]  idx_q;
  logic [IDX_W-1:0]  stop_q;
  logic [ADDR_W-1:0] addr_q;
  logic              wb_vld_q;
  logic [ADDR_W-1:0] wb_val_q;

  logic [IDX_W-1:0]  idx_nxt;
  logic              last_step;
  logic [ADDR_W-1:0] addr_nxt;
  logic              take_start;
  logic              xfer_fire;

  rr_idx_stepper #(.IDX_W(IDX_W)) u_idx (
    .idx_now (idx_q),
    .idx_stop(stop_q),
    .dir     (dir_q),
    .idx_next(idx_nxt),
    .at_stop (last_step)
  );

  rr_addr_stepper #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_addr (
    .addr_now (addr_q),
    .dir      (dir_q),
    .addr_next(addr_nxt)
  );

  always_comb begin
    start_ready   = !busy_q;
    take_start    = start_valid && !busy_q;
    mem_req_valid = busy_q && !abort;
    xfer_fire     = mem_req_valid && mem_req_ready;
    mem_req_write = (dir_q == DIR_STORE_UP);
    mem_req_addr  = addr_q;
    mem_req_wdata = rf_rd_data;
    rf_rd_idx     = idx_q;
    rf_wr_en      = xfer_fire && (dir_q == DIR_LOAD_DOWN);
    rf_wr_idx     = idx_q;
    rf_wr_data    = mem_rdata;
    busy          = busy_q;
    cur_idx       = idx_q;
    cur_addr      = addr_q;
    addr_wb_valid = wb_vld_q;
    addr_wb_value = wb_val_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      dir_q    <= DIR_STORE_UP;
      idx_q    <= '0;
      stop_q   <= '0;
      addr_q   <= '0;
      wb_vld_q <= 1'b0;
      wb_val_q <= '0;
    end else begin
      wb_vld_q <= 1'b0;
      if (take_start) begin
        busy_q <= 1'b1;
        dir_q  <= start_is_load ? DIR_LOAD_DOWN : DIR_STORE_UP;
        idx_q  <= start_first;
        stop_q <= start_last;
        addr_q <= start_base;
      end else if (busy_q && abort) begin
        // progress registers keep the next pending transfer for resumption
        busy_q <= 1'b0;
      end else if (xfer_fire) begin
        if (last_step) begin
          busy_q   <= 1'b0;
          wb_vld_q <= 1'b1;
          wb_val_q <= addr_q;
        end else begin
          idx_q  <= idx_nxt;
          addr_q <= addr_nxt;
        end
      end
    end
  end
endmodule

// File: rtl/regrange_xfer_chk.sv
module regrange_xfer_chk #(
  parameter int IDX_W      = 6,
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              abort,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [IDX_W-1:0]  rf_rd_idx,
  input logic              rf_wr_en,
  input logic [IDX_W-1:0]  cur_idx,
  input logic [ADDR_W-1:0] cur_addr,
  input logic [IDX_W-1:0]  stop_idx,
  input logic              addr_wb_valid,
  input logic [ADDR_W-1:0] addr_wb_value
);
  localparam logic [IDX_W-1:0]  I1 = IDX_W'(1);
  localparam logic [ADDR_W-1:0] AW = ADDR_W'(WORD_BYTES);

  logic fire;
  assign fire = mem_req_valid && mem_req_ready;

  assert_req_needs_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> busy);

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      ($stable(mem_req_addr) && $stable(rf_rd_idx) && $stable(mem_req_write)));

  assert_store_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && mem_req_write && cur_idx != stop_idx) |=>
      (cur_idx == $past(cur_idx) + I1 && cur_addr == $past(cur_addr) + AW && busy));

  assert_load_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !mem_req_write && cur_idx != stop_idx) |=>
      (cur_idx == $past(cur_idx) - I1 && cur_addr == $past(cur_addr) - AW && busy));

  assert_load_wr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_en |-> (fire && !mem_req_write));

  assert_final_wb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cur_idx == stop_idx) |=>
      (!busy && addr_wb_valid && addr_wb_value == $past(cur_addr) && $stable(cur_addr)));

  assert_wb_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    addr_wb_valid |=> !addr_wb_valid);

  assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fire && !abort) |=> (busy && $stable(cur_idx) && $stable(cur_addr)));

  assert_abort_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && abort) |=>
      (!busy && !addr_wb_valid && $stable(cur_idx) && $stable(cur_addr)));
endmodule

bind regrange_xfer_seq regrange_xfer_chk #(
  .IDX_W(IDX_W), .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .abort        (abort),
  .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write),
  .mem_req_addr (mem_req_addr),
  .rf_rd_idx    (rf_rd_idx),
  .rf_wr_en     (rf_wr_en),
  .cur_idx      (cur_idx),
  .cur_addr     (cur_addr),
  .stop_idx     (stop_q),
  .addr_wb_valid(addr_wb_valid),
  .addr_wb_value(addr_wb_value)
);

// File: tb/test_regrange_xfer_seq.sv
`timescale 1ns/1ps
module test_regrange_xfer_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_valid = 1'b0;
  logic        start_ready;
  logic        start_is_load = 1'b0;
  logic [5:0]  start_first = '0;
  logic [5:0]  start_last = '0;
  logic [31:0] start_base = '0;
  logic        abort = 1'b0;
  logic        busy;
  logic [5:0]  cur_idx;
  logic [31:0] cur_addr;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic        mem_req_write;
  logic [31:0] mem_req_addr;
  logic [63:0] mem_req_wdata;
  logic [63:0] mem_rdata;
  logic [5:0]  rf_rd_idx;
  logic [63:0] rf_rd_data;
  logic        rf_wr_en;
  logic [5:0]  rf_wr_idx;
  logic [63:0] rf_wr_data;
  logic        addr_wb_valid;
  logic [31:0] addr_wb_value;

  logic [63:0] mem_m [512];
  logic [63:0] rf_m  [64];
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  assign mem_rdata  = mem_m[mem_req_addr[11:3]];
  assign rf_rd_data = rf_m[rf_rd_idx];

  always @(posedge clk) begin
    if (rf_wr_en) rf_m[rf_wr_idx] <= rf_wr_data;
    if (mem_req_valid && mem_req_ready && mem_req_write)
      mem_m[mem_req_addr[11:3]] <= mem_req_wdata;
  end

  regrange_xfer_seq i_regrange_xfer_seq (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int xfer_count(input bit ld, input logic [5:0] f, input logic [5:0] l);
    logic [5:0] d;
    d = ld ? 6'(f - l) : 6'(l - f);
    return int'(d) + 1;
  endfunction

  function automatic logic [5:0] idx_at(input bit ld, input logic [5:0] f, input int k);
    return ld ? 6'(f - 6'(k)) : 6'(f + 6'(k));
  endfunction

  function automatic logic [31:0] addr_at(input bit ld, input logic [31:0] b, input int k);
    return ld ? 32'(b - 32'(k * 8)) : 32'(b + 32'(k * 8));
  endfunction

  // called at a negedge; returns at a negedge
  task automatic run_op(input bit ld, input logic [5:0] f, input logic [5:0] l,
                        input logic [31:0] b, input int rdy_pct, input int abort_after,
                        input bit poke);
    int n;
    int k;
    n = xfer_count(ld, f, l);
    k = 0;
    start_valid = 1'b1; start_is_load = ld; start_first = f; start_last = l; start_base = b;
    #1;
    chk("R8 start_ready idle", start_ready, 1'b1);
    @(negedge clk);
    start_valid = 1'b0;
    #1;
    chk("R2 busy", busy, 1'b1);
    chk("R2 cur_idx", cur_idx, f);
    chk("R2 cur_addr", cur_addr, b);
    while (k < n) begin
      if (k == abort_after) begin
        abort = 1'b1; mem_req_ready = 1'b1;
        #1;
        chk("R9 valid low in abort", mem_req_valid, 1'b0);
        @(negedge clk);
        abort = 1'b0; mem_req_ready = 1'b0;
        #1;
        chk("R9 idle", busy, 1'b0);
        chk("R9 idx kept", cur_idx, idx_at(ld, f, k));
        chk("R9 addr kept", cur_addr, addr_at(ld, b, k));
        chk("R9 no wb", addr_wb_valid, 1'b0);
        return;
      end
      mem_req_ready = (($urandom % 100) < rdy_pct);
      if (poke) begin
        start_valid = 1'b1; start_first = 6'($urandom); start_base = $urandom;
        start_is_load = ~ld;
      end
      #1;
      chk("R7 valid", mem_req_valid, 1'b1);
      if (poke) chk("R8 start_ready busy", start_ready, 1'b0);
      chk(ld ? "R4 addr" : "R3 addr", mem_req_addr, addr_at(ld, b, k));
      if (ld) begin
        chk("R4 write flag", mem_req_write, 1'b0);
        chk("R4 wr_idx", rf_wr_idx, idx_at(ld, f, k));
        chk("R4 wr_en", rf_wr_en, mem_req_ready);
        chk("R4 wr_data", rf_wr_data, mem_m[addr_at(ld, b, k) >> 3 & 511]);
      end else begin
        chk("R3 write flag", mem_req_write, 1'b1);
        chk("R3 rd_idx", rf_rd_idx, idx_at(ld, f, k));
        chk("R3 wdata", mem_req_wdata, rf_m[idx_at(ld, f, k)]);
      end
      if (mem_req_ready) k++;
      @(negedge clk);
    end
    start_valid = 1'b0; mem_req_ready = 1'b0;
    #1;
    chk("R5 busy low after last", busy, 1'b0);
    chk("R6 wb pulse", addr_wb_valid, 1'b1);
    chk("R6 wb value", addr_wb_value, addr_at(ld, b, n - 1));
    chk("R6 final addr held", cur_addr, addr_at(ld, b, n - 1));
    @(negedge clk);
    #1;
    chk("R6 wb single", addr_wb_valid, 1'b0);
    chk("R7 idle no req", mem_req_valid, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R5 watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [5:0]  sv_idx;
    logic [31:0] sv_addr;
    void'($urandom(32'd1234));
    for (int i = 0; i < 512; i++) mem_m[i] = {$urandom, $urandom};
    for (int i = 0; i < 64; i++) rf_m[i] = {$urandom, $urandom};
    repeat (3) @(negedge clk);
    #1;
    chk("R1 busy", busy, 1'b0);
    chk("R1 start_ready", start_ready, 1'b1);
    chk("R1 valid", mem_req_valid, 1'b0);
    chk("R1 wb", addr_wb_valid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // single register, both directions
    run_op(1'b0, 6'd5, 6'd5, 32'h100, 100, -1, 1'b0);
    run_op(1'b1, 6'd9, 6'd9, 32'h200, 100, -1, 1'b0);
    // R5 wrap on store and load
    run_op(1'b0, 6'd62, 6'd1, 32'h300, 70, -1, 1'b0);
    run_op(1'b1, 6'd1, 6'd62, 32'h340, 70, -1, 1'b0);
    // full range load with back-pressure and start pokes (R8)
    run_op(1'b1, 6'd63, 6'd0, 32'h800, 60, -1, 1'b1);
    // store then load back: mirror restore
    run_op(1'b0, 6'd16, 6'd31, 32'h400, 50, -1, 1'b1);
    for (int i = 16; i < 32; i++) rf_m[i] = '0;
    run_op(1'b1, 6'd31, 6'd16, 32'h478, 50, -1, 1'b0);
    for (int i = 16; i < 32; i++) chk("R4 restored", rf_m[i], mem_m[(32'h400 >> 3) + i - 16]);
    // R9 abort and resume
    run_op(1'b0, 6'd10, 6'd20, 32'h600, 100, 3, 1'b0);
    sv_idx = cur_idx; sv_addr = cur_addr;
    chk("R9 resume idx", sv_idx, 6'd13);
    run_op(1'b0, sv_idx, 6'd20, sv_addr, 80, -1, 1'b0);
    run_op(1'b1, 6'd40, 6'd30, 32'h700, 100, 5, 1'b0);
    sv_idx = cur_idx; sv_addr = cur_addr;
    run_op(1'b1, sv_idx, 6'd30, sv_addr, 80, -1, 1'b0);
    // random mix
    for (int t = 0; t < 30; t++) begin
      run_op(1'($urandom), 6'($urandom), 6'($urandom), {$urandom} & 32'hFFFF_FFF8,
             30 + int'($urandom % 71), -1, 1'($urandom));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule